// File: doc/BRIEF.md
# Segmented Per-Lane Key Crossbar

This block carries lookup keys from a row of match processors to a row of memory clusters and brings the lookup results back. Every processor offers a fixed number of key lanes each cycle. Instead of one wide crossbar joining every key to every key, the block holds one narrow crossbar per lane index. Lane k of a processor can therefore only reach lane k of a cluster. Even so, one processor can point each of its lanes at a different cluster in the same cycle, and the wire count stays close to that of a single processor-to-cluster crossbar.

Each lane request carries a valid bit and a destination bitmask with one bit per cluster. A single set bit sends the key to one cluster. Several set bits multicast the key, which serves a table split over several clusters. A cluster lane accepts one key per cycle. When two processors aim at the same cluster lane, the lower-numbered processor gets it and the other is flagged. The clusters answer with a hit bit and a data word after a fixed lookup latency. The block remembers which processor owns each cluster lane and steers the answer back to the lane that asked.

The request path has one register stage and so does the return path. A result therefore reaches the processor `LOOKUP_LAT + 2` cycles after its request was presented.

Top module: `xbar_seg_top`

## Requirements
- R1: A valid request on processor p, lane k, whose mask has bit c set and which wins cluster c, appears one cycle later on cluster c lane k. It carries the same key, and the cluster's source index equals p.
- R2: A mask with several bits set delivers the key to every selected cluster in the same cycle.
- R3: The lanes of one processor are routed independently, so two lanes can reach two different clusters in the same cycle.
- R4: When several processors target one cluster lane, the lowest-numbered one is forwarded. Every other contender has its conflict flag (same processor and lane index) raised one cycle after the request. A contender is still forwarded to any cluster in its mask that it does win.
- R5: A result appears on the originating processor lane exactly `LOOKUP_LAT + 2` cycles after the request, for one cycle only. Its valid bit is set exactly when the request won at least one cluster.
- R6: The returned hit bit is the OR of the hit bits from the clusters the request won. The returned data comes from the lowest-numbered such cluster that hit, and it is zero when none hit.
- R7: A request with its valid bit low, or with an empty mask, forwards nothing, raises no conflict and returns no result.
- R8: Hit and data inputs from a cluster lane with no outstanding forwarded key are ignored, and no result is produced.
- R9: While reset is asserted and right after it, every valid, conflict, hit, key and data output is zero.
- R10: A new set of requests may be presented every cycle. Each set is forwarded and returned on its own schedule, and later sets do not disturb earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_PROC*N_LANE | Request valid, bit p*N_LANE+k |
| req_dest | input | N_PROC*N_LANE*N_CLUS | Destination cluster mask per processor lane, bit c of field p*N_LANE+k |
| req_key | input | N_PROC*N_LANE*KEY_W | Key per processor lane |
| req_conflict | output | N_PROC*N_LANE | Request lost at least one cluster lane (one cycle after request) |
| clu_valid | output | N_CLUS*N_LANE | Key valid toward cluster c lane k, bit c*N_LANE+k |
| clu_key | output | N_CLUS*N_LANE*KEY_W | Key toward each cluster lane |
| clu_src | output | N_CLUS*N_LANE*SRC_W | Index of the processor that owns the cluster lane |
| clu_hit | input | N_CLUS*N_LANE | Lookup hit from each cluster lane, LOOKUP_LAT cycles after its key |
| clu_data | input | N_CLUS*N_LANE*DATA_W | Lookup data from each cluster lane |
| res_valid | output | N_PROC*N_LANE | Result valid on processor lane |
| res_hit | output | N_PROC*N_LANE | Merged hit on processor lane |
| res_data | output | N_PROC*N_LANE*DATA_W | Result data on processor lane |

## Verification
A wrong winner choice shows on the cluster ports in the very next cycle: the wrong source index or key appears, or a conflict flag is wrong. A fault in the return delay line stays hidden until the results come back, `LOOKUP_LAT + 2` cycles after the request. It then shows as a result on the wrong processor lane, a result one cycle early or late, or a hit merged from a cluster the request never won. Back-to-back request sets with different owners expose any stage of the delay line that mixes entries from neighbouring cycles, because each set has its own expected owner.

// File: rtl/xbar_seg_pkg.sv
package xbar_seg_pkg;

    // Width of an index able to name n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_lane_fwd.sv
// One lane index: priority selection per cluster and registered key forwarding.
module xbar_lane_fwd #(
    parameter int N_PROC = 8,
    parameter int N_CLUS = 8,
    parameter int KEY_W  = 80,
    parameter int SRC_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PROC-1:0]         in_v,
    input  logic [N_PROC*N_CLUS-1:0]  in_mask,
    input  logic [N_PROC*KEY_W-1:0]   in_key,
    output logic [N_CLUS-1:0]         out_v,
    output logic [N_CLUS*KEY_W-1:0]   out_key,
    output logic [N_CLUS*SRC_W-1:0]   out_src,
    output logic [N_PROC-1:0]         out_lost
);

    logic [N_CLUS-1:0]        own_v;
    logic [SRC_W-1:0]         own_idx [N_CLUS];
    logic [N_CLUS*KEY_W-1:0]  key_nxt;
    logic [N_CLUS*SRC_W-1:0]  src_nxt;
    logic [N_PROC-1:0]        lost_nxt;

    // Lowest-numbered requester of each cluster owns it.
    always_comb begin
        for (int c = 0; c < N_CLUS; c++) begin
            own_v[c]   = 1'b0;
            own_idx[c] = '0;
            for (int p = N_PROC - 1; p >= 0; p--) begin
                if (in_v[p] && in_mask[p*N_CLUS + c]) begin
                    own_v[c]   = 1'b1;
                    own_idx[c] = SRC_W'(p);
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < N_CLUS; c++) begin
            key_nxt[c*KEY_W +: KEY_W] = own_v[c] ?
                in_key[int'(own_idx[c])*KEY_W +: KEY_W] : '0;
            src_nxt[c*SRC_W +: SRC_W] = own_idx[c];
        end
    end

    // A requester loses if any cluster in its mask went to someone else.
    always_comb begin
        for (int p = 0; p < N_PROC; p++) begin
            lost_nxt[p] = 1'b0;
            for (int c = 0; c < N_CLUS; c++) begin
                if (in_v[p] && in_mask[p*N_CLUS + c] && (own_idx[c] != SRC_W'(p)))
                    lost_nxt[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v    <= '0;
            out_key  <= '0;
            out_src  <= '0;
            out_lost <= '0;
        end else begin
            out_v    <= own_v;
            out_key  <= key_nxt;
            out_src  <= src_nxt;
            out_lost <= lost_nxt;
        end
    end

endmodule

// File: rtl/xbar_lane_ret.sv
// One lane index: ownership delay line and registered result steering.
module xbar_lane_ret #(
    parameter int N_PROC     = 8,
    parameter int N_CLUS     = 8,
    parameter int DATA_W     = 32,
    parameter int SRC_W      = 3,
    parameter int LOOKUP_LAT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CLUS-1:0]         sent_v,
    input  logic [N_CLUS*SRC_W-1:0]   sent_src,
    input  logic [N_CLUS-1:0]         lk_hit,
    input  logic [N_CLUS*DATA_W-1:0]  lk_data,
    output logic [N_PROC-1:0]         ret_v,
    output logic [N_PROC-1:0]         ret_hit,
    output logic [N_PROC*DATA_W-1:0]  ret_data
);

    localparam int LAST = LOOKUP_LAT - 1;

    logic [N_CLUS-1:0]       dl_v   [LOOKUP_LAT];
    logic [N_CLUS*SRC_W-1:0] dl_src [LOOKUP_LAT];

    logic [N_PROC-1:0]        v_nxt;
    logic [N_PROC-1:0]        h_nxt;
    logic [N_PROC*DATA_W-1:0] d_nxt;

    // Ownership record travels alongside the lookup in the clusters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < LOOKUP_LAT; j++) begin
                dl_v[j]   <= '0;
                dl_src[j] <= '0;
            end
        end else begin
            dl_v[0]   <= sent_v;
            dl_src[0] <= sent_src;
            for (int j = 1; j < LOOKUP_LAT; j++) begin
                dl_v[j]   <= dl_v[j-1];
                dl_src[j] <= dl_src[j-1];
            end
        end
    end

    // Merge the answers of every cluster owned by each processor.
    always_comb begin
        for (int p = 0; p < N_PROC; p++) begin
            v_nxt[p]                  = 1'b0;
            h_nxt[p]                  = 1'b0;
            d_nxt[p*DATA_W +: DATA_W] = '0;
            for (int c = 0; c < N_CLUS; c++) begin
                if (dl_v[LAST][c] && (dl_src[LAST][c*SRC_W +: SRC_W] == SRC_W'(p))) begin
                    v_nxt[p] = 1'b1;
                    if (lk_hit[c] && !h_nxt[p]) begin
                        h_nxt[p]                  = 1'b1;
                        d_nxt[p*DATA_W +: DATA_W] = lk_data[c*DATA_W +: DATA_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_v    <= '0;
            ret_hit  <= '0;
            ret_data <= '0;
        end else begin
            ret_v    <= v_nxt;
            ret_hit  <= h_nxt;
            ret_data <= d_nxt;
        end
    end

endmodule

// File: rtl/xbar_seg_top.sv
module xbar_seg_top
    import xbar_seg_pkg::*;
#(
    parameter int N_PROC     = 8,
    parameter int N_CLUS     = 8,
    parameter int N_LANE     = 8,
    parameter int KEY_W      = 80,
    parameter int DATA_W     = 32,
    parameter int LOOKUP_LAT = 2,
    localparam int SRC_W     = idx_bits(N_PROC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_PROC*N_LANE-1:0]          req_valid,
    input  logic [N_PROC*N_LANE*N_CLUS-1:0]   req_dest,
    input  logic [N_PROC*N_LANE*KEY_W-1:0]    req_key,
    output logic [N_PROC*N_LANE-1:0]          req_conflict,
    output logic [N_CLUS*N_LANE-1:0]          clu_valid,
    output logic [N_CLUS*N_LANE*KEY_W-1:0]    clu_key,
    output logic [N_CLUS*N_LANE*SRC_W-1:0]    clu_src,
    input  logic [N_CLUS*N_LANE-1:0]          clu_hit,
    input  logic [N_CLUS*N_LANE*DATA_W-1:0]   clu_data,
    output logic [N_PROC*N_LANE-1:0]          res_valid,
    output logic [N_PROC*N_LANE-1:0]          res_hit,
    output logic [N_PROC*N_LANE*DATA_W-1:0]   res_data
);

    for (genvar k = 0; k < N_LANE; k++) begin : g_lane
        logic [N_PROC-1:0]        ln_v;
        logic [N_PROC*N_CLUS-1:0] ln_mask;
        logic [N_PROC*KEY_W-1:0]  ln_key;
        logic [N_PROC-1:0]        ln_lost;
        logic [N_CLUS-1:0]        ln_cv;
        logic [N_CLUS*KEY_W-1:0]  ln_ck;
        logic [N_CLUS*SRC_W-1:0]  ln_cs;
        logic [N_CLUS-1:0]        ln_hit;
        logic [N_CLUS*DATA_W-1:0] ln_dat;
        logic [N_PROC-1:0]        ln_rv;
        logic [N_PROC-1:0]        ln_rh;
        logic [N_PROC*DATA_W-1:0] ln_rd;

        for (genvar p = 0; p < N_PROC; p++) begin : g_proc
            localparam int PI = p*N_LANE + k;
            assign ln_v[p]                        = req_valid[PI];
            assign ln_mask[p*N_CLUS +: N_CLUS]    = req_dest[PI*N_CLUS +: N_CLUS];
            assign ln_key[p*KEY_W +: KEY_W]       = req_key[PI*KEY_W +: KEY_W];
            assign req_conflict[PI]               = ln_lost[p];
            assign res_valid[PI]                  = ln_rv[p];
            assign res_hit[PI]                    = ln_rh[p];
            assign res_data[PI*DATA_W +: DATA_W]  = ln_rd[p*DATA_W +: DATA_W];
        end

        for (genvar c = 0; c < N_CLUS; c++) begin : g_clus
            localparam int CI = c*N_LANE + k;
            assign clu_valid[CI]                  = ln_cv[c];
            assign clu_key[CI*KEY_W +: KEY_W]     = ln_ck[c*KEY_W +: KEY_W];
            assign clu_src[CI*SRC_W +: SRC_W]     = ln_cs[c*SRC_W +: SRC_W];
            assign ln_hit[c]                      = clu_hit[CI];
            assign ln_dat[c*DATA_W +: DATA_W]     = clu_data[CI*DATA_W +: DATA_W];
        end

        xbar_lane_fwd #(
            .N_PROC (N_PROC),
            .N_CLUS (N_CLUS),
            .KEY_W  (KEY_W),
            .SRC_W  (SRC_W)
        ) u_fwd (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_v     (ln_v),
            .in_mask  (ln_mask),
            .in_key   (ln_key),
            .out_v    (ln_cv),
            .out_key  (ln_ck),
            .out_src  (ln_cs),
            .out_lost (ln_lost)
        );

        xbar_lane_ret #(
            .N_PROC     (N_PROC),
            .N_CLUS     (N_CLUS),
            .DATA_W     (DATA_W),
            .SRC_W      (SRC_W),
            .LOOKUP_LAT (LOOKUP_LAT)
        ) u_ret (
            .clk      (clk),
            .rst_n    (rst_n),
            .sent_v   (ln_cv),
            .sent_src (ln_cs),
            .lk_hit   (ln_hit),
            .lk_data  (ln_dat),
            .ret_v    (ln_rv),
            .ret_hit  (ln_rh),
            .ret_data (ln_rd)
        );
    end

endmodule

// File: rtl/xbar_seg_chk.sv
module xbar_seg_chk #(
    parameter int N_PROC     = 8,
    parameter int N_CLUS     = 8,
    parameter int N_LANE     = 8,
    parameter int KEY_W      = 80,
    parameter int DATA_W     = 32,
    parameter int LOOKUP_LAT = 2,
    parameter int SRC_W      = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [N_PROC*N_LANE-1:0]          req_valid,
    input logic [N_PROC*N_LANE*N_CLUS-1:0]   req_dest,
    input logic [N_PROC*N_LANE*KEY_W-1:0]    req_key,
    input logic [N_PROC*N_LANE-1:0]          req_conflict,
    input logic [N_CLUS*N_LANE-1:0]          clu_valid,
    input logic [N_CLUS*N_LANE*KEY_W-1:0]    clu_key,
    input logic [N_CLUS*N_LANE*SRC_W-1:0]    clu_src,
    input logic [N_PROC*N_LANE-1:0]          res_valid,
    input logic [N_PROC*N_LANE-1:0]          res_hit,
    input logic [N_PROC*N_LANE*DATA_W-1:0]   res_data
);

    localparam int AGE = LOOKUP_LAT + 2;

    logic [N_PROC*N_LANE-1:0]        pv;
    logic [N_PROC*N_LANE*N_CLUS-1:0] pd;
    logic [N_PROC*N_LANE*KEY_W-1:0]  pk;
    logic [N_PROC*N_LANE-1:0]        hist [AGE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv <= '0;
            pd <= '0;
            pk <= '0;
            for (int j = 0; j < AGE; j++) hist[j] <= '0;
        end else begin
            pv <= req_valid;
            pd <= req_dest;
            pk <= req_key;
            hist[0] <= req_valid;
            for (int j = 1; j < AGE; j++) hist[j] <= hist[j-1];
        end
    end

    for (genvar k = 0; k < N_LANE; k++) begin : g_k
        for (genvar c = 0; c < N_CLUS; c++) begin : g_c
            localparam int CI = c*N_LANE + k;
            logic [SRC_W-1:0] s;
            assign s = clu_src[CI*SRC_W +: SRC_W];

            // R1: a forwarded key was requested toward this cluster last cycle
            p_fwd_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
                clu_valid[CI] |-> (pv[int'(s)*N_LANE + k] &&
                                   pd[(int'(s)*N_LANE + k)*N_CLUS + c]));

            // R1: the forwarded key is the owner's key
            p_fwd_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
                clu_valid[CI] |-> (clu_key[CI*KEY_W +: KEY_W] ==
                                   pk[(int'(s)*N_LANE + k)*KEY_W +: KEY_W]));
        end
    end

    for (genvar i = 0; i < N_PROC*N_LANE; i++) begin : g_i
        // R4: only a lane that made a request can be flagged
        p_conflict_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
            req_conflict[i] |-> pv[i]);

        // R5: a result matches a request of the right age
        p_res_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid[i] |-> hist[AGE-1][i]);

        // R6: hit implies a valid result
        p_hit_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
            res_hit[i] |-> res_valid[i]);

        // R6: a miss returns zero data
        p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid[i] && !res_hit[i]) |-> (res_data[i*DATA_W +: DATA_W] == '0));
    end

endmodule

bind xbar_seg_top xbar_seg_chk #(
    .N_PROC     (N_PROC),
    .N_CLUS     (N_CLUS),
    .N_LANE     (N_LANE),
    .KEY_W      (KEY_W),
    .DATA_W     (DATA_W),
    .LOOKUP_LAT (LOOKUP_LAT),
    .SRC_W      (SRC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_dest     (req_dest),
    .req_key      (req_key),
    .req_conflict (req_conflict),
    .clu_valid    (clu_valid),
    .clu_key      (clu_key),
    .clu_src      (clu_src),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_data     (res_data)
);

// File: tb/tb_xbar_seg_top.sv
module tb_xbar_seg_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int NC  = 4;
    localparam int NL  = 2;
    localparam int KW  = 16;
    localparam int DW  = 16;
    localparam int LAT = 2;
    localparam int SW  = 2;
    localparam int NS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP*NL-1:0]    req_valid = '0;
    logic [NP*NL*NC-1:0] req_dest  = '0;
    logic [NP*NL*KW-1:0] req_key   = '0;
    logic [NP*NL-1:0]    req_conflict;
    logic [NC*NL-1:0]    clu_valid;
    logic [NC*NL*KW-1:0] clu_key;
    logic [NC*NL*SW-1:0] clu_src;
    logic [NC*NL-1:0]    clu_hit;
    logic [NC*NL*DW-1:0] clu_data;
    logic [NP*NL-1:0]    res_valid;
    logic [NP*NL-1:0]    res_hit;
    logic [NP*NL*DW-1:0] res_data;

    int checks = 0;
    int failures = 0;
    logic force_hit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_seg_top #(
        .N_PROC(NP), .N_CLUS(NC), .N_LANE(NL),
        .KEY_W(KW), .DATA_W(DW), .LOOKUP_LAT(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dest(req_dest), .req_key(req_key),
        .req_conflict(req_conflict),
        .clu_valid(clu_valid), .clu_key(clu_key), .clu_src(clu_src),
        .clu_hit(clu_hit), .clu_data(clu_data),
        .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data)
    );

    // Cluster stub: hit when key bit c is set, data = key ^ (c+1)*0x0101, LAT cycles later.
    logic [NC*NL-1:0]    sh   [LAT];
    logic [NC*NL*DW-1:0] sdat [LAT];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LAT; j++) begin
                sh[j]   <= '0;
                sdat[j] <= '0;
            end
        end else begin
            for (int ci = 0; ci < NC*NL; ci++) begin
                sh[0][ci] <= clu_valid[ci] && clu_key[ci*KW + ci/NL];
                sdat[0][ci*DW +: DW] <= clu_valid[ci] ?
                    (clu_key[ci*KW +: KW] ^ (16'(ci/NL + 1) * 16'h0101)) : '0;
            end
            for (int j = 1; j < LAT; j++) begin
                sh[j]   <= sh[j-1];
                sdat[j] <= sdat[j-1];
            end
        end
    end

    assign clu_hit  = force_hit ? '1 : sh[LAT-1];
    assign clu_data = force_hit ? '1 : sdat[LAT-1];

    // Stimulus slots
    logic [NP*NL-1:0]    sv [NS];
    logic [NP*NL*NC-1:0] sd [NS];
    logic [NP*NL*KW-1:0] sk [NS];

    // Expected values
    logic [NC*NL-1:0]    ex_cv;
    logic [NC*NL*KW-1:0] ex_ck;
    logic [NC*NL*SW-1:0] ex_cs;
    logic [NP*NL-1:0]    ex_cf;
    logic [NP*NL-1:0]    ex_rv;
    logic [NP*NL-1:0]    ex_rh;
    logic [NP*NL*DW-1:0] ex_rd;

    task automatic chk(input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr(input int s);
        sv[s] = '0; sd[s] = '0; sk[s] = '0;
    endtask

    task automatic setreq(input int s, input int p, input int k,
                          input logic [NC-1:0] mask, input logic [KW-1:0] key);
        sv[s][p*NL+k]            = 1'b1;
        sd[s][(p*NL+k)*NC +: NC] = mask;
        sk[s][(p*NL+k)*KW +: KW] = key;
    endtask

    task automatic drive(input int s);
        req_valid = sv[s]; req_dest = sd[s]; req_key = sk[s];
    endtask

    task automatic idle();
        req_valid = '0; req_dest = '0; req_key = '0;
    endtask

    // Expected outputs from the requirements for one request set.
    task automatic model(input int s);
        logic          wv [NC][NL];
        logic [SW-1:0] wi [NC][NL];
        ex_cv = '0; ex_ck = '0; ex_cs = '0; ex_cf = '0;
        ex_rv = '0; ex_rh = '0; ex_rd = '0;
        for (int k = 0; k < NL; k++) begin
            for (int c = 0; c < NC; c++) begin
                wv[c][k] = 1'b0; wi[c][k] = '0;
                for (int p = 0; p < NP; p++) begin
                    if (!wv[c][k] && sv[s][p*NL+k] && sd[s][(p*NL+k)*NC+c]) begin
                        wv[c][k] = 1'b1; wi[c][k] = SW'(p);
                    end
                end
                if (wv[c][k]) begin
                    ex_cv[c*NL+k] = 1'b1;
                    ex_ck[(c*NL+k)*KW +: KW] = sk[s][(int'(wi[c][k])*NL+k)*KW +: KW];
                    ex_cs[(c*NL+k)*SW +: SW] = wi[c][k];
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < NL; k++) begin
                logic [KW-1:0] key;
                logic got;
                key = sk[s][(p*NL+k)*KW +: KW];
                got = 1'b0;
                for (int c = 0; c < NC; c++) begin
                    if (sv[s][p*NL+k] && sd[s][(p*NL+k)*NC+c]) begin
                        if (wi[c][k] != SW'(p)) ex_cf[p*NL+k] = 1'b1;
                        else begin
                            ex_rv[p*NL+k] = 1'b1;
                            if (key[c] && !got) begin
                                got = 1'b1;
                                ex_rd[(p*NL+k)*DW +: DW] = key ^ (16'(c + 1) * 16'h0101);
                            end
                        end
                    end
                end
                ex_rh[p*NL+k] = got;
            end
        end
    endtask

    task automatic check_fwd(input string req);
        chk(req, "clu_valid", clu_valid, ex_cv);
        chk(req, "clu_key", clu_key, ex_ck);
        chk(req, "clu_src", clu_src, ex_cs);
        chk(req, "req_conflict", req_conflict, ex_cf);
    endtask

    task automatic check_ret(input string req);
        chk(req, "res_valid", res_valid, ex_rv);
        chk(req, "res_hit", res_hit, ex_rh);
        chk(req, "res_data", res_data, ex_rd);
    endtask

    task automatic run_one(input int s, input string req);
        @(negedge clk); drive(s);
        @(negedge clk); model(s); check_fwd(req); idle();
        repeat (LAT) @(negedge clk);
        chk({req, " R5"}, "result not early", res_valid, '0);
        @(negedge clk); check_ret(req);
        @(negedge clk);
        chk({req, " R5"}, "result one cycle only", res_valid, '0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9", "clu_valid after reset", clu_valid, '0);
        chk("R9", "conflict after reset", req_conflict, '0);
        chk("R9", "res outputs after reset", {res_valid, res_hit, res_data}, '0);
    endtask

    task automatic t_unicast();
        clr(0);
        setreq(0, 1, 0, 4'b0100, 16'h0a04);
        run_one(0, "R1 R5");
    endtask

    task automatic t_multicast();
        clr(0);
        setreq(0, 0, 1, 4'b1011, 16'h500a);
        setreq(0, 2, 0, 4'b0011, 16'h0100);
        run_one(0, "R2 R6");
    endtask

    task automatic t_split_lanes();
        clr(0);
        setreq(0, 2, 0, 4'b0001, 16'h0001);
        setreq(0, 2, 1, 4'b1000, 16'h0008);
        run_one(0, "R3");
    endtask

    task automatic t_conflict();
        clr(0);
        setreq(0, 1, 0, 4'b0010, 16'h0002);
        setreq(0, 3, 0, 4'b0110, 16'h0004);
        setreq(0, 0, 1, 4'b0001, 16'h0001);
        setreq(0, 2, 1, 4'b0001, 16'h0001);
        run_one(0, "R4");
    endtask

    task automatic t_empty();
        clr(0);
        setreq(0, 0, 0, 4'b0000, 16'hffff);
        sd[0][(1*NL+1)*NC +: NC] = 4'b1111;
        sk[0][(1*NL+1)*KW +: KW] = 16'hffff;
        run_one(0, "R7");
    endtask

    task automatic t_spurious();
        @(negedge clk); idle(); force_hit = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        chk("R8", "res_valid with stray hits", res_valid, '0);
        chk("R8", "res_hit with stray hits", res_hit, '0);
        force_hit = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic t_stream();
        clr(1); clr(2);
        setreq(1, 0, 0, 4'b0001, 16'h0001);
        setreq(2, 0, 0, 4'b0001, 16'h1000);
        setreq(2, 3, 1, 4'b1111, 16'h000c);
        @(negedge clk); drive(1);
        @(negedge clk); model(1); check_fwd("R10"); drive(2);
        @(negedge clk); model(2); check_fwd("R10"); idle();
        repeat (LAT) @(negedge clk);
        model(1); check_ret("R10 first");
        @(negedge clk);
        model(2); check_ret("R10 second");
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_unicast();
        t_multicast();
        t_split_lanes();
        t_conflict();
        t_empty();
        t_spurious();
        t_stream();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule